// File: doc/BRIEF.md
# Return Address Stack Predictor

This block predicts the target of subroutine returns at the fetch stage of an in-order pipeline. Each cycle it inspects the word being fetched. A call is a direct jump or a register-indirect jump whose link destination is x1. For a call, it saves the address of the following instruction on a small circular stack. A return is a register-indirect jump that writes x0, reads x1 and has a zero offset. For a return, it takes the most recent saved address off the stack and offers it as the next fetch address in the same cycle. If the stack is empty, no prediction is made and fetch continues sequentially.

The predicted flag and target travel down the pipeline with the jump. A small resolution unit compares them with the real target (register plus sign-extended offset, bit 0 cleared) once the jump reaches execute. It raises a redirect whenever the prediction was missing or wrong, and the pipeline then squashes the wrong-path work as it would for a branch mispredict. Entries pushed or popped by squashed instructions are not repaired.

The stack control is a three-state machine. EMPTY holds no entry: PUSH goes to PARTIAL (or straight to FULL for a one-entry stack), and UNDERFLOW (a pop) stays in EMPTY. PARTIAL holds some entries: PUSH stays in PARTIAL or goes to FULL on the last free slot, and POP stays in PARTIAL or goes to EMPTY on the last entry. FULL holds every slot: OVERWRITE (a push) stays in FULL and replaces the oldest entry, and POP returns to PARTIAL.

Top module: `ras_predictor`

## Requirements
- R1: After reset the stack is empty: a return fetched first gives pred_valid=0 and pred_target=0.
- R2: A call is an instruction with opcode bits[6:0]=1101111, or with opcode 1100111 and bits[14:12]=000, in either case with rd bits[11:7]=1. A call fetched with fetch_fire=1 pushes fetch_pc+4.
- R3: A return is opcode 1100111 with bits[14:12]=000, rd=0, rs1 bits[19:15]=1 and immediate bits[31:20]=0. When it is fetched with fetch_fire=1 and the stack is not empty, pred_valid=1 and pred_target equals the most recently pushed address in the same cycle, and that entry is removed.
- R4: Returns take addresses in last-in first-out order relative to the calls.
- R5: A return fetched on an empty stack gives pred_valid=0 and pred_target=0, and the stack stays empty and usable.
- R6: The stack holds DEPTH (default 8) addresses. A push onto a full stack discards the oldest entry, so after DEPTH+1 calls the next DEPTH returns yield the newest DEPTH addresses, newest first, and the one after that finds the stack empty.
- R7: Any other word leaves the stack unchanged and gives pred_valid=0. This includes register-indirect jumps with a nonzero offset, with rs1 other than 1, with rd other than 0 or 1, or with bits[14:12] not 000, and direct jumps with rd other than 1.
- R8: With fetch_fire=0 the stack is unchanged and pred_valid=0, whatever the fetched word.
- R9: A register-indirect jump with rd=1 and rs1=1 is a call only: it pushes and gives no prediction.
- R10: ex_fix_pc = (ex_rs1_val + sign-extended ex_imm) with bit 0 cleared. ex_redirect=1 exactly when ex_jalr=1 and not (ex_pred_valid=1 and ex_pred_target equals ex_fix_pc), combinationally. A redirect does not alter the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_fire | input | 1 | A new instruction is fetched this cycle |
| fetch_pc | input | AW | Address of the fetched instruction |
| fetch_instr | input | 32 | Fetched instruction word |
| pred_valid | output | 1 | Return predicted from a stack entry |
| pred_target | output | AW | Predicted return address, zero when none |
| ex_jalr | input | 1 | Execute stage holds a register-indirect jump |
| ex_pred_valid | input | 1 | That jump was predicted at fetch |
| ex_pred_target | input | AW | Target predicted at fetch |
| ex_rs1_val | input | AW | Base register value of the jump |
| ex_imm | input | 12 | Offset field of the jump |
| ex_redirect | output | 1 | Fetch must restart at ex_fix_pc |
| ex_fix_pc | output | AW | Computed jump target |

## Verification
The stack is driven with runs of 0 to DEPTH+2 calls followed by one more return than calls. These runs separate plain last-in first-out order, the boundary where the stack just fills, the overwrite of the oldest entry, and the empty-pop fallback. Calls alternate between the direct and register-indirect forms, so a decoder that recognises only one of them shows up as missing entries. Near-miss encodings, stalled fetches and the x1-to-x1 jump are placed between a push and a pop, so an unwanted push or pop shows up in the address the later return yields. The resolution unit is swept over base values and offsets, including negative offsets and odd sums, each with a correct, a wrong and an absent prediction.

// File: rtl/ras_pkg.sv
`timescale 1ns/1ps
package ras_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } ras_state_e;

    localparam logic [6:0] OPC_JUMP_DIRECT   = 7'b1101111;
    localparam logic [6:0] OPC_JUMP_INDIRECT = 7'b1100111;
    localparam logic [4:0] REG_LINK          = 5'd1;
    localparam logic [4:0] REG_ZERO          = 5'd0;

    typedef struct packed {
        logic [11:0] imm;
        logic [4:0]  rs1;
        logic [2:0]  funct3;
        logic [4:0]  rd;
        logic [6:0]  opcode;
    } itype_word_t;

endpackage

// File: rtl/ras_decode.sv
`timescale 1ns/1ps
module ras_decode
    import ras_pkg::*;
(
    input  logic [31:0] instr,
    output logic        is_call,
    output logic        is_ret
);
    itype_word_t w;
    logic        direct_jump;
    logic        indirect_jump;

    always_comb begin
        w             = itype_word_t'(instr);
        direct_jump   = (w.opcode == OPC_JUMP_DIRECT);
        indirect_jump = (w.opcode == OPC_JUMP_INDIRECT) && (w.funct3 == 3'b000);
        // R2 R9: any link write to x1 is a call
        is_call       = (direct_jump || indirect_jump) && (w.rd == REG_LINK);
        // R3: indirect jump through x1 with no link and no offset
        is_ret        = indirect_jump && (w.rd == REG_ZERO) &&
                        (w.rs1 == REG_LINK) && (w.imm == 12'd0);
    end
endmodule

// File: rtl/ras_stack.sv
`timescale 1ns/1ps
module ras_stack
    import ras_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic                          pop,
    input  logic [AW-1:0]                 push_addr,
    output logic                          pop_hit,
    output logic [AW-1:0]                 top_addr,
    output logic [$clog2(DEPTH+1)-1:0]    occupancy,
    output ras_state_e                    state
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_ALMOST = CNT_W'(DEPTH - 1);

    ras_state_e       state_q, state_d;
    logic [CNT_W-1:0] occ_q, occ_d;
    logic [PTR_W-1:0] head_q, head_d;
    logic [AW-1:0]    slot_rd [DEPTH];

    function automatic logic [PTR_W-1:0] step_up(input logic [PTR_W-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] step_down(input logic [PTR_W-1:0] p);
        return (p == '0) ? LAST_SLOT : p - 1'b1;
    endfunction

    // one register per slot, written when the head points at it
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [AW-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (push && (head_q == PTR_W'(g))) begin
                word_q <= push_addr;
            end
        end
        assign slot_rd[g] = word_q;
    end

    // next-state logic: PUSH, POP, OVERWRITE, UNDERFLOW
    always_comb begin
        state_d = state_q;
        occ_d   = occ_q;
        head_d  = head_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (push) begin
                    occ_d   = CNT_W'(1);
                    head_d  = step_up(head_q);
                    state_d = (DEPTH == 1) ? ST_FULL : ST_PARTIAL;
                end
            end
            ST_PARTIAL: begin
                if (push) begin
                    occ_d   = occ_q + 1'b1;
                    head_d  = step_up(head_q);
                    state_d = (occ_q == CNT_ALMOST) ? ST_FULL : ST_PARTIAL;
                end else if (pop) begin
                    occ_d   = occ_q - 1'b1;
                    head_d  = step_down(head_q);
                    state_d = (occ_q == CNT_W'(1)) ? ST_EMPTY : ST_PARTIAL;
                end
            end
            ST_FULL: begin
                if (push) begin
                    head_d  = step_up(head_q);
                end else if (pop) begin
                    occ_d   = CNT_ALMOST;
                    head_d  = step_down(head_q);
                    state_d = (DEPTH == 1) ? ST_EMPTY : ST_PARTIAL;
                end
            end
            default: begin
                state_d = ST_EMPTY;
                occ_d   = '0;
                head_d  = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            occ_q   <= '0;
            head_q  <= '0;
        end else begin
            state_q <= state_d;
            occ_q   <= occ_d;
            head_q  <= head_d;
        end
    end

    // outputs
    always_comb begin
        pop_hit   = pop && (state_q != ST_EMPTY);
        top_addr  = pop_hit ? slot_rd[step_down(head_q)] : '0;
        occupancy = occ_q;
        state     = state_q;
    end

    logic unused_full;
    assign unused_full = (CNT_FULL == '0);
endmodule

// File: rtl/ras_resolve.sv
`timescale 1ns/1ps
module ras_resolve #(
    parameter int AW = 32
) (
    input  logic          ex_jalr,
    input  logic          ex_pred_valid,
    input  logic [AW-1:0] ex_pred_target,
    input  logic [AW-1:0] ex_rs1_val,
    input  logic [11:0]   ex_imm,
    output logic          ex_redirect,
    output logic [AW-1:0] ex_fix_pc
);
    logic [AW-1:0] sum;
    logic          guess_ok;

    // R10: compare the carried guess with the computed target
    always_comb begin
        sum         = ex_rs1_val + {{(AW-12){ex_imm[11]}}, ex_imm};
        ex_fix_pc   = {sum[AW-1:1], 1'b0};
        guess_ok    = ex_pred_valid && (ex_pred_target == ex_fix_pc);
        ex_redirect = ex_jalr && !guess_ok;
    end
endmodule

// File: rtl/ras_predictor.sv
`timescale 1ns/1ps
module ras_predictor
    import ras_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_fire,
    input  logic [AW-1:0] fetch_pc,
    input  logic [31:0]   fetch_instr,
    output logic          pred_valid,
    output logic [AW-1:0] pred_target,
    input  logic          ex_jalr,
    input  logic          ex_pred_valid,
    input  logic [AW-1:0] ex_pred_target,
    input  logic [AW-1:0] ex_rs1_val,
    input  logic [11:0]   ex_imm,
    output logic          ex_redirect,
    output logic [AW-1:0] ex_fix_pc
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             dec_call;
    logic             dec_ret;
    logic             do_push;
    logic             do_pop;
    logic [AW-1:0]    link_addr;
    logic [CNT_W-1:0] stk_occ;
    ras_state_e       stk_state;

    ras_decode u_decode (
        .instr   (fetch_instr),
        .is_call (dec_call),
        .is_ret  (dec_ret)
    );

    assign do_push   = fetch_fire && dec_call;
    assign do_pop    = fetch_fire && dec_ret;
    assign link_addr = fetch_pc + AW'(4);

    ras_stack #(.DEPTH(DEPTH), .AW(AW)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .pop       (do_pop),
        .push_addr (link_addr),
        .pop_hit   (pred_valid),
        .top_addr  (pred_target),
        .occupancy (stk_occ),
        .state     (stk_state)
    );

    ras_resolve #(.AW(AW)) u_resolve (
        .ex_jalr        (ex_jalr),
        .ex_pred_valid  (ex_pred_valid),
        .ex_pred_target (ex_pred_target),
        .ex_rs1_val     (ex_rs1_val),
        .ex_imm         (ex_imm),
        .ex_redirect    (ex_redirect),
        .ex_fix_pc      (ex_fix_pc)
    );
endmodule

// File: rtl/ras_checker.sv
`timescale 1ns/1ps
module ras_checker
    import ras_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       fire,
    input logic                       is_call,
    input logic                       is_ret,
    input logic [$clog2(DEPTH+1)-1:0] occ,
    input ras_state_e                 st,
    input logic                       pred_valid,
    input logic                       ex_jalr,
    input logic                       ex_redirect
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    // R1
    empty_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_EMPTY) == (occ == '0));

    // R6
    full_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FULL) == (occ == CNT_FULL));

    // R2
    push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && is_call && occ < CNT_FULL) |=> (occ == $past(occ) + 1'b1));

    // R6
    overwrite_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && is_call && occ == CNT_FULL) |=> (occ == CNT_FULL));

    // R3
    pop_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && is_ret && occ != '0) |=> (occ == $past(occ) - 1'b1));

    // R5
    underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && is_ret && occ == '0) |-> !pred_valid ##1 (occ == '0));

    // R3
    hit_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |-> (fire && is_ret && occ != '0));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(occ));

    // R7
    other_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !is_call && !is_ret) |=> $stable(occ));

    // R9
    call_not_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_call && is_ret));

    // R10
    redirect_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ex_redirect |-> ex_jalr);
endmodule

bind ras_predictor ras_checker #(.DEPTH(DEPTH)) u_ras_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fetch_fire),
    .is_call     (dec_call),
    .is_ret      (dec_ret),
    .occ         (stk_occ),
    .st          (stk_state),
    .pred_valid  (pred_valid),
    .ex_jalr     (ex_jalr),
    .ex_redirect (ex_redirect)
);

// File: tb/test_ras_predictor.sv
`timescale 1ns/1ps
module test_ras_predictor;
    localparam int DEPTH = 8;
    localparam int AW    = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          fetch_fire;
    logic [AW-1:0] fetch_pc;
    logic [31:0]   fetch_instr;
    logic          pred_valid;
    logic [AW-1:0] pred_target;
    logic          ex_jalr;
    logic          ex_pred_valid;
    logic [AW-1:0] ex_pred_target;
    logic [AW-1:0] ex_rs1_val;
    logic [11:0]   ex_imm;
    logic          ex_redirect;
    logic [AW-1:0] ex_fix_pc;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;
    logic [AW-1:0] mdl [DEPTH];
    int  mcnt = 0;

    always #10 clk = ~clk;

    ras_predictor #(.DEPTH(DEPTH), .AW(AW)) i_ras_predictor (
        .clk(clk), .rst_n(rst_n), .fetch_fire(fetch_fire), .fetch_pc(fetch_pc),
        .fetch_instr(fetch_instr), .pred_valid(pred_valid), .pred_target(pred_target),
        .ex_jalr(ex_jalr), .ex_pred_valid(ex_pred_valid), .ex_pred_target(ex_pred_target),
        .ex_rs1_val(ex_rs1_val), .ex_imm(ex_imm), .ex_redirect(ex_redirect),
        .ex_fix_pc(ex_fix_pc)
    );

    function automatic logic [31:0] enc_jal(input logic [4:0] rd);
        return {20'h00200, rd, 7'b1101111};
    endfunction

    function automatic logic [31:0] enc_jalr(input logic [4:0] rd, input logic [4:0] rs1,
                                              input logic [11:0] imm, input logic [2:0] f3);
        return {imm, rs1, f3, rd, 7'b1100111};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // kind: 0 other, 1 call, 2 return
    task automatic fetch(input logic [31:0] pc, input logic [31:0] instr,
                         input int kind, input bit fire, input string req);
        logic          ev;
        logic [31:0]   et;
        @(negedge clk);
        fetch_pc    = pc;
        fetch_instr = instr;
        fetch_fire  = fire;
        #2;
        ev = 1'b0;
        et = '0;
        if (fire && kind == 2 && mcnt > 0) begin
            ev = 1'b1;
            et = mdl[mcnt-1];
        end
        chk({req, " valid"}, {31'b0, pred_valid}, {31'b0, ev});
        chk({req, " target"}, pred_target, et);
        if (fire && kind == 1) begin
            if (mcnt == DEPTH) begin
                for (int i = 0; i < DEPTH - 1; i++) mdl[i] = mdl[i+1];
                mcnt--;
            end
            mdl[mcnt] = pc + 32'd4;
            mcnt++;
        end else if (fire && kind == 2 && mcnt > 0) begin
            mcnt--;
        end
        @(posedge clk);
        #1 fetch_fire = 1'b0;
    endtask

    task automatic ex_case(input logic j, input logic pv, input logic [31:0] pt,
                           input logic [31:0] rs1, input logic [11:0] imm);
        logic [31:0] act;
        logic        redir;
        ex_jalr        = j;
        ex_pred_valid  = pv;
        ex_pred_target = pt;
        ex_rs1_val     = rs1;
        ex_imm         = imm;
        #1;
        act   = (rs1 + {{20{imm[11]}}, imm}) & 32'hFFFF_FFFE;
        redir = j && !(pv && pt == act);
        chk("R10 fix_pc", ex_fix_pc, act);
        chk("R10 redirect", {31'b0, ex_redirect}, {31'b0, redir});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] ret_w;
        logic [31:0] rs_list [4];
        logic [11:0] im_list [6];
        ret_w = enc_jalr(5'd0, 5'd1, 12'd0, 3'd0);
        rst_n = 1'b0;
        fetch_fire = 1'b0;
        fetch_pc = '0;
        fetch_instr = '0;
        ex_jalr = 1'b0;
        ex_pred_valid = 1'b0;
        ex_pred_target = '0;
        ex_rs1_val = '0;
        ex_imm = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: first return after reset sees an empty stack
        fetch(32'h0000_0100, ret_w, 2, 1'b1, "R1 reset");

        // R2 R4 R5 R6: runs of n calls then n+1 returns
        for (int n = 0; n <= DEPTH + 2; n++) begin
            for (int k = 0; k < n; k++)
                fetch(32'h1000_0000 + n * 32'h400 + k * 32'h10,
                      (k % 2 == 1) ? enc_jalr(5'd1, 5'd6, 12'h010, 3'd0) : enc_jal(5'd1),
                      1, 1'b1, "R2 call");
            for (int k = 0; k <= n; k++)
                fetch(32'h2000_0000 + k * 4, ret_w, 2, 1'b1,
                      (n > DEPTH) ? "R6 overwrite pop" :
                      (k == n)    ? "R5 empty pop" : "R4 lifo pop");
        end

        // R7: near-miss encodings leave the stack alone
        fetch(32'h3000_0000, enc_jal(5'd1), 1, 1'b1, "R2 call");
        fetch(32'h3000_0040, enc_jalr(5'd0, 5'd1, 12'h004, 3'd0), 0, 1'b1, "R7 offset");
        fetch(32'h3000_0044, enc_jalr(5'd0, 5'd5, 12'h000, 3'd0), 0, 1'b1, "R7 rs1");
        fetch(32'h3000_0048, enc_jalr(5'd5, 5'd1, 12'h000, 3'd0), 0, 1'b1, "R7 rd");
        fetch(32'h3000_004C, enc_jalr(5'd0, 5'd1, 12'h000, 3'd1), 0, 1'b1, "R7 funct3");
        fetch(32'h3000_0050, enc_jalr(5'd1, 5'd1, 12'h000, 3'd2), 0, 1'b1, "R7 funct3 link");
        fetch(32'h3000_0054, enc_jal(5'd0), 0, 1'b1, "R7 plain jump");
        fetch(32'h3000_0058, 32'h0010_0093, 0, 1'b1, "R7 alu op");
        fetch(32'h3000_0060, ret_w, 2, 1'b1, "R7 pop after");
        fetch(32'h3000_0064, ret_w, 2, 1'b1, "R7 empty after");

        // R8: stalled fetch has no effect
        fetch(32'h4000_0000, enc_jal(5'd1), 1, 1'b1, "R2 call");
        fetch(32'h4000_0010, enc_jal(5'd1), 1, 1'b0, "R8 stalled call");
        fetch(32'h4000_0014, ret_w, 2, 1'b0, "R8 stalled ret");
        fetch(32'h4000_0018, ret_w, 2, 1'b1, "R8 pop after");
        fetch(32'h4000_001C, ret_w, 2, 1'b1, "R8 empty after");

        // R9: x1-to-x1 indirect jump is a call only
        fetch(32'h5000_0000, enc_jal(5'd1), 1, 1'b1, "R2 call");
        fetch(32'h5000_0100, enc_jalr(5'd1, 5'd1, 12'h000, 3'd0), 1, 1'b1, "R9 link jump");
        fetch(32'h5000_0200, ret_w, 2, 1'b1, "R9 pop newest");
        fetch(32'h5000_0204, ret_w, 2, 1'b1, "R9 pop older");
        fetch(32'h5000_0208, ret_w, 2, 1'b1, "R9 empty");

        // R10: resolution sweep, stack untouched by redirects
        rs_list[0] = 32'h0000_0000; rs_list[1] = 32'h0000_1000;
        rs_list[2] = 32'h7FFF_FFF1; rs_list[3] = 32'hFFFF_FFFE;
        im_list[0] = 12'h000; im_list[1] = 12'h001; im_list[2] = 12'h7FF;
        im_list[3] = 12'h800; im_list[4] = 12'hFFF; im_list[5] = 12'h123;
        fetch(32'h6000_0000, enc_jal(5'd1), 1, 1'b1, "R2 call");
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 6; b++) begin
                logic [31:0] good;
                good = (rs_list[a] + {{20{im_list[b][11]}}, im_list[b]}) & 32'hFFFF_FFFE;
                ex_case(1'b1, 1'b1, good, rs_list[a], im_list[b]);
                ex_case(1'b1, 1'b1, good ^ 32'h4, rs_list[a], im_list[b]);
                ex_case(1'b1, 1'b0, good, rs_list[a], im_list[b]);
                ex_case(1'b0, 1'b0, 32'h0, rs_list[a], im_list[b]);
            end
        end
        ex_jalr = 1'b0;
        fetch(32'h6000_0100, ret_w, 2, 1'b1, "R10 stack kept");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule